// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block decides whether a write to an erase command register may start a flash erase. Software reaches it through a simple register bus made of an address, a write strobe, write data and read data. It holds three registers:

- an erase command register,
- a page number register,
- a whole-array enable register.

An erase only starts when a command byte matches one of two fixed patterns and the matching arming write came before it. Each arming write allows exactly one erase. A page number that has already been used, or a missing enable, therefore blocks the erase.

When a command passes its checks, the block issues a one-cycle request to the flash array side. The request is either a page request, which carries the stored 7-bit page number, or a whole-array request. The block then treats the flash side as busy until the flash reports completion. The flash array's own timing lies outside this block. Register offsets are parameters, with defaults command = 0x10, page = 0x11 and enable = 0x12.

Top module: `flash_erase_seq`

## Requirements
- R1: A write of 0x55 to the command offset, while the page is armed and the block is idle, raises `req_page` for exactly one cycle, starting the cycle after the write. `req_num` carries the stored page number at that time.
- R2: A write of 0xAA to the command offset, while the whole-array enable is armed, `dbg_en` is high in the write cycle and the block is idle, raises `req_mass` for exactly one cycle, starting the cycle after the write.
- R3: A command write of any value other than 0x55 or 0xAA produces no request and leaves both arming flags unchanged.
- R4: A 0x55 command issued when no page-offset write has occurred since the last page request (or since reset) produces no request.
- R5: Issuing a page request clears the page arming, so a repeated 0x55 needs a fresh page-offset write. Issuing a whole-array request clears the enable arming in the same way.
- R6: A page-offset write stores bits [6:0] of the data and arms the page. A read of the page offset returns the stored number, with bit 7 at 0.
- R7: A 0xAA command with `dbg_en` low produces no request.
- R8: After reset the page number is 0, neither flag is armed, no request is raised, and reads of all three offsets return 0x00.
- R9: The command register is write-only, so a read of its offset returns 0x00. A read of the enable offset returns the enable arming in bit 0.
- R10: The block is busy while `flash_busy` is high, and also from the issue of a request until the cycle after `flash_done` is seen. While busy, command writes are ignored and both arming flags are left as they are.
- R11: A 0x55 or 0xAA command rejected for a missing precondition clears no arming flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| dbg_en | input | 1 | Debug access enabled; required for a whole-array erase |
| flash_busy | input | 1 | Flash array is erasing |
| flash_done | input | 1 | One-cycle completion pulse from the flash array |
| req_page | output | 1 | One-cycle page erase request |
| req_mass | output | 1 | One-cycle whole-array erase request |
| req_num | output | 7 | Page number for the request |

## Verification
The bench first issues a command that is one bit away from a valid pattern, and then follows it with a valid command. A design that cleared the arming on an unrecognised value would fail to issue the later request.

It also repeats a page command without rewriting the page number. A design that kept the arming would erase the stale page a second time.

A whole-array command is sent with `dbg_en` low and then again with it high. A design that ignored the debug input, or cleared the enable on rejection, would misbehave on one of the two.

Busy is tested in two ways. Commands are sent while `flash_busy` is high, and also in the gap after a request but before `flash_done`. A design that ignored that gap would start a second erase before the first had finished.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 7,
  parameter logic [AW-1:0] CMD_OFS = 8'h10,
  parameter logic [AW-1:0] PAGE_OFS = 8'h11,
  parameter logic [AW-1:0] MEN_OFS = 8'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dbg_en,
  input  logic          flash_busy,
  input  logic          flash_done,
  output logic          req_page,
  output logic          req_mass,
  output logic [PW-1:0] req_num
);

  localparam logic [DW-1:0] PAT_PAGE = DW'(8'h55);
  localparam logic [DW-1:0] PAT_MASS = DW'(8'hAA);

  logic [PW-1:0] page_q;
  logic          page_arm, mass_arm, pending;

  wire wr_cmd  = reg_wr && reg_addr == CMD_OFS;
  wire wr_page = reg_wr && reg_addr == PAGE_OFS;
  wire wr_men  = reg_wr && reg_addr == MEN_OFS;
  wire busy    = flash_busy || pending;
  wire go_page = wr_cmd && !busy && reg_wdata == PAT_PAGE && page_arm;
  wire go_mass = wr_cmd && !busy && reg_wdata == PAT_MASS && mass_arm && dbg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      page_arm <= 1'b0;
      mass_arm <= 1'b0;
      pending  <= 1'b0;
      req_page <= 1'b0;
      req_mass <= 1'b0;
    end else begin
      req_page <= go_page;
      req_mass <= go_mass;
      if (wr_page) begin
        page_q   <= reg_wdata[PW-1:0];
        page_arm <= 1'b1;
      end else if (go_page) begin
        page_arm <= 1'b0;
      end
      if (wr_men)       mass_arm <= 1'b1;
      else if (go_mass) mass_arm <= 1'b0;
      if (go_page || go_mass) pending <= 1'b1;
      else if (flash_done)    pending <= 1'b0;
    end
  end

  assign req_num = page_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == PAGE_OFS)     reg_rdata[PW-1:0] = page_q;
    else if (reg_addr == MEN_OFS) reg_rdata[0] = mass_arm;
  end

  // R1
  page_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_page |=> !req_page);
  // R2
  mass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_mass |=> !req_mass);
  // R3
  page_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_page |-> $past(reg_wr && reg_addr == CMD_OFS && reg_wdata == PAT_PAGE));
  // R7
  mass_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_mass |-> $past(dbg_en && reg_wr && reg_addr == CMD_OFS && reg_wdata == PAT_MASS));
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |=> !(req_page || req_mass));
  // R1
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_page, req_mass}));

endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic reg_wr = 0, dbg_en = 0, flash_busy = 0, flash_done = 0;
  logic [7:0] reg_rdata;
  logic req_page, req_mass;
  logic [6:0] req_num;
  int total = 0, bad = 0;
  logic p1, m1, p2, m2;
  logic [6:0] n1;

  localparam logic [7:0] CMD = 8'h10, PG = 8'h11, MEN = 8'h12;

  always #2.5 clk = ~clk;

  flash_erase_seq uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_en(dbg_en), .flash_busy(flash_busy),
    .flash_done(flash_done), .req_page(req_page), .req_mass(req_mass), .req_num(req_num));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1; p1 = req_page; m1 = req_mass; n1 = req_num;
    @(negedge clk); reg_wr = 0;
    @(posedge clk); #1; p2 = req_page; m2 = req_mass;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic done_pulse();
    @(negedge clk); flash_done = 1;
    @(negedge clk); flash_done = 0;
  endtask

  task automatic t_reset();
    chk("R8 req_page", req_page, 0);
    chk("R8 req_mass", req_mass, 0);
    rd(PG, 8'h00, "R8 page reg");
    rd(CMD, 8'h00, "R8 cmd reg");
    rd(MEN, 8'h00, "R8 enable reg");
  endtask

  task automatic t_page_unarmed();
    wr(CMD, 8'h55);
    chk("R4 no page req unarmed", p1, 0);
  endtask

  task automatic t_page_basic();
    wr(PG, 8'hFF);
    rd(PG, 8'h7F, "R6 page readback");
    wr(CMD, 8'h55);
    chk("R1 req_page", p1, 1);
    chk("R1 req_num", n1, 7'h7F);
    chk("R1 single pulse", p2, 0);
    rd(CMD, 8'h00, "R9 cmd write-only");
    done_pulse();
    wr(CMD, 8'h55);
    chk("R5 page arming consumed", p1, 0);
  endtask

  task automatic t_bad_patterns();
    wr(PG, 8'h23);
    wr(CMD, 8'h54);
    chk("R3 0x54 ignored", p1 | m1, 0);
    wr(CMD, 8'h00);
    chk("R3 0x00 ignored", p1 | m1, 0);
    wr(CMD, 8'hAB);
    chk("R3 0xAB ignored", p1 | m1, 0);
    wr(CMD, 8'h55);
    chk("R3 arming kept", p1, 1);
    chk("R3 req_num", n1, 7'h23);
    done_pulse();
  endtask

  task automatic t_mass();
    wr(CMD, 8'hAA);
    chk("R2 no mass unarmed", m1, 0);
    wr(MEN, 8'h01);
    rd(MEN, 8'h01, "R9 enable readback");
    dbg_en = 0;
    wr(CMD, 8'hAA);
    chk("R7 no mass w/o debug", m1, 0);
    rd(MEN, 8'h01, "R11 enable kept after reject");
    dbg_en = 1;
    wr(CMD, 8'hAA);
    chk("R2 req_mass", m1, 1);
    chk("R2 mass not page", p1, 0);
    chk("R2 single pulse", m2, 0);
    rd(MEN, 8'h00, "R5 enable consumed");
    done_pulse();
    wr(CMD, 8'hAA);
    chk("R5 mass needs rearm", m1, 0);
    dbg_en = 0;
  endtask

  task automatic t_busy();
    wr(PG, 8'h05);
    flash_busy = 1;
    wr(CMD, 8'h55);
    chk("R10 ignored while busy", p1, 0);
    flash_busy = 0;
    wr(CMD, 8'h55);
    chk("R10 arming kept after busy", p1, 1);
    chk("R10 req_num", n1, 7'h05);
    wr(PG, 8'h06);
    wr(CMD, 8'h55);
    chk("R10 ignored until done", p1, 0);
    done_pulse();
    @(negedge clk);
    wr(CMD, 8'h55);
    chk("R10 issue after done", p1, 1);
    chk("R10 req_num after done", n1, 7'h06);
    done_pulse();
  endtask

  task automatic t_reject_keep();
    wr(PG, 8'h11);
    wr(MEN, 8'h01);
    wr(CMD, 8'hAA);
    chk("R11 mass reject no req", m1, 0);
    wr(CMD, 8'h55);
    chk("R11 page still armed", p1, 1);
    rd(MEN, 8'h01, "R11 enable still armed");
    done_pulse();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    fork
      begin
        t_reset();
        t_page_unarmed();
        t_page_basic();
        t_bad_patterns();
        t_mass();
        t_busy();
        t_reject_keep();
      end
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule